// File: doc/BRIEF.md
# Multichannel SAR Conversion Sequencer

This block drives an external 8-bit successive-approximation converter that has eight multiplexed analog inputs. A start strobe captures a channel number and a conversion-rate choice. The block then holds the input multiplexer on that channel and opens a sampling window. After the window it runs a binary search from the most significant bit down. Each step places a trial code on the DAC and keeps or drops the bit under test according to a one-bit comparator answer.

Every conversion occupies a frame of fixed length, counted in conversion-clock periods. The conversion clock is either the system clock or half of it. The bit steps share the clocks left after sampling equally. Any remainder is idle time at the end of the frame, so completion always lands on the same period. When the frame ends, the result register loads, a sticky done flag rises and an interrupt pulse lasts one cycle.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, result_o is 0, done_o is 0, irq_o is 0, sample_o is 0 and mux_sel_o is 0.
- R2: A start accepted while idle latches ch_i. mux_sel_o shows that channel from the cycle after the start until the next accepted start, whatever ch_i does meanwhile.
- R3: sample_o is high for exactly 12 conversion-clock periods, beginning in the cycle after the accepted start. That is 12 system cycles when half_clk_i=0 and 24 when half_clk_i=1.
- R4: done_o and irq_o rise exactly 160 conversion-clock periods after the start edge. That is 160 system cycles with half_clk_i=0 (full rate) and 320 with half_clk_i=1 (half rate). The rate bit is latched at start.
- R5: Bits are decided MSB first. A bit is kept when cmp_i=1, meaning input ≥ trial level. With an ideal comparator, the result equals the selected input value, including codes 0x00 and 0xFF.
- R6: During each bit step, dac_o holds the bits already decided, the bit under test set to 1 and all lower bits 0. The first trial is 0x80, and it appears when sampling ends.
- R7: A start strobe while a conversion is running is ignored. Channel, rate, timing and result are unaffected.
- R8: result_o changes only at completion. irq_o is high for exactly one cycle, at the same time as done_o rises. done_o stays high until the next accepted start, which clears it in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| ch_i | input | 3 | Requested channel |
| half_clk_i | input | 1 | 1 = conversion clock is half the system clock |
| cmp_i | input | 1 | Comparator: 1 when input ≥ DAC level |
| mux_sel_o | output | 3 | Analog multiplexer select |
| sample_o | output | 1 | Sampling switch enable |
| dac_o | output | 8 | DAC trial code |
| result_o | output | 8 | Last completed conversion |
| done_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
The case hardest to reach from the ports is a start strobe that arrives in the middle of a conversion. It must come with a different channel and rate, and it must be shown to change nothing. The stimulus puts such a strobe at a random point inside each randomized frame, sometimes during sampling and sometimes late in the bit steps. The bench then checks that the frame length, the multiplexer select and the final code all follow the first start. Directed runs cover input codes 0x00, 0xFF, 0x80 and 0x7F at both rates, since these sit on the edges of the binary search.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SAMP = 2'd1,
        PH_BITS = 2'd2,
        PH_PAD  = 2'd3
    } phase_e;
endpackage

// File: rtl/sar_tick_gen.sv
`timescale 1ns/1ps
// Conversion-clock enable: every cycle at full rate, every second cycle at half rate.
module sar_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    input  logic half_i,
    output logic tick_o
);
    typedef struct packed {
        logic half;
        logic ph;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (restart_i) begin
            s_d.half = half_i;
            s_d.ph   = 1'b0;
        end else if (run_i) begin
            s_d.ph = ~s_q.ph;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = run_i && !restart_i && (!s_q.half || s_q.ph);
endmodule

// File: rtl/sar_phase_ctrl.sv
`timescale 1ns/1ps
// Frame sequencing: sampling window, equal bit slots, idle padding.
module sar_phase_ctrl
    import sar_pkg::*;
#(
    parameter int FRAME  = 160,
    parameter int SAMPLE = 12,
    parameter int RES    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go_i,
    input  logic                     tick_i,
    output logic                     busy_o,
    output logic                     sample_o,
    output logic                     bit_active_o,
    output logic                     decide_o,
    output logic [$clog2(RES)-1:0]   bit_idx_o,
    output logic                     finish_o
);
    localparam int PER_BIT = (FRAME - SAMPLE) / RES;
    localparam int CNT_W   = $clog2(FRAME + 1);
    localparam int SLOT_W  = (PER_BIT > 1) ? $clog2(PER_BIT) : 1;
    localparam int IDX_W   = $clog2(RES);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic [SLOT_W-1:0]  slot;
        logic [IDX_W-1:0]   idx;
    } st_t;

    st_t s_d, s_q;

    logic last_tick;
    logic last_slot;

    assign last_tick = (s_q.cnt == CNT_W'(FRAME - 1));
    assign last_slot = (s_q.slot == SLOT_W'(PER_BIT - 1));

    always_comb begin
        s_d = s_q;
        if (go_i) begin
            s_d.phase = PH_SAMP;
            s_d.cnt   = '0;
            s_d.slot  = '0;
            s_d.idx   = IDX_W'(RES - 1);
        end else if (tick_i) begin
            s_d.cnt = s_q.cnt + 1'b1;
            if (last_tick) begin
                s_d.phase = PH_IDLE;
            end else begin
                case (s_q.phase)
                    PH_SAMP: begin
                        if (s_q.cnt == CNT_W'(SAMPLE - 1)) begin
                            s_d.phase = PH_BITS;
                            s_d.slot  = '0;
                        end
                    end
                    PH_BITS: begin
                        if (last_slot) begin
                            s_d.slot = '0;
                            if (s_q.idx == '0) s_d.phase = PH_PAD;
                            else               s_d.idx   = s_q.idx - 1'b1;
                        end else begin
                            s_d.slot = s_q.slot + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o       = (s_q.phase != PH_IDLE);
    assign sample_o     = (s_q.phase == PH_SAMP);
    assign bit_active_o = (s_q.phase == PH_BITS);
    assign decide_o     = tick_i && (s_q.phase == PH_BITS) && last_slot;
    assign bit_idx_o    = s_q.idx;
    assign finish_o     = tick_i && busy_o && last_tick;
endmodule

// File: rtl/sar_approx_reg.sv
`timescale 1ns/1ps
// Successive-approximation register: forms the trial code and keeps or drops the tested bit.
module sar_approx_reg #(
    parameter int RES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear_i,
    input  logic                   bit_active_i,
    input  logic                   decide_i,
    input  logic [$clog2(RES)-1:0] bit_idx_i,
    input  logic                   cmp_i,
    output logic [RES-1:0]         trial_o,
    output logic [RES-1:0]         acc_nxt_o
);
    typedef struct packed {
        logic [RES-1:0] acc;
    } st_t;

    st_t s_d, s_q;

    for (genvar i = 0; i < RES; i++) begin : g_trial
        assign trial_o[i] = s_q.acc[i] |
                            (bit_active_i && (bit_idx_i == ($clog2(RES))'(i)));
    end

    always_comb begin
        s_d = s_q;
        if (clear_i)       s_d.acc = '0;
        else if (decide_i) s_d.acc = cmp_i ? trial_o : s_q.acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc_nxt_o = s_d.acc;
endmodule

// File: rtl/sar_seq_top.sv
`timescale 1ns/1ps
module sar_seq_top #(
    parameter int CHANNELS = 8,
    parameter int RES      = 8,
    parameter int FRAME    = 160,
    parameter int SAMPLE   = 12,
    localparam int CH_W    = $clog2(CHANNELS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [CH_W-1:0] ch_i,
    input  logic            half_clk_i,
    input  logic            cmp_i,
    output logic [CH_W-1:0] mux_sel_o,
    output logic            sample_o,
    output logic [RES-1:0]  dac_o,
    output logic [RES-1:0]  result_o,
    output logic            done_o,
    output logic            irq_o
);
    localparam int IDX_W = $clog2(RES);

    typedef struct packed {
        logic [CH_W-1:0] ch;
        logic [RES-1:0]  result;
        logic            done;
        logic            irq;
    } st_t;

    st_t s_d, s_q;

    logic             busy_w;
    logic             go_w;
    logic             tick_w;
    logic             bit_active_w;
    logic             decide_w;
    logic             finish_w;
    logic [IDX_W-1:0] bit_idx_w;
    logic [RES-1:0]   acc_nxt_w;

    assign go_w = start_i && !busy_w;

    sar_tick_gen u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (busy_w),
        .restart_i (go_w),
        .half_i    (half_clk_i),
        .tick_o    (tick_w)
    );

    sar_phase_ctrl #(
        .FRAME  (FRAME),
        .SAMPLE (SAMPLE),
        .RES    (RES)
    ) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (go_w),
        .tick_i       (tick_w),
        .busy_o       (busy_w),
        .sample_o     (sample_o),
        .bit_active_o (bit_active_w),
        .decide_o     (decide_w),
        .bit_idx_o    (bit_idx_w),
        .finish_o     (finish_w)
    );

    sar_approx_reg #(
        .RES (RES)
    ) u_sar (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (go_w),
        .bit_active_i (bit_active_w),
        .decide_i     (decide_w),
        .bit_idx_i    (bit_idx_w),
        .cmp_i        (cmp_i),
        .trial_o      (dac_o),
        .acc_nxt_o    (acc_nxt_w)
    );

    always_comb begin
        s_d     = s_q;
        s_d.irq = finish_w;
        if (go_w) begin
            s_d.ch   = ch_i;
            s_d.done = 1'b0;
        end
        if (finish_w) begin
            s_d.result = acc_nxt_w;
            s_d.done   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mux_sel_o = s_q.ch;
    assign result_o  = s_q.result;
    assign done_o    = s_q.done;
    assign irq_o     = s_q.irq;
endmodule

// File: rtl/sar_seq_chk.sv
`timescale 1ns/1ps
module sar_seq_chk #(
    parameter int RES    = 8,
    parameter int FRAME  = 160,
    parameter int SAMPLE = 12,
    parameter int CH_W   = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            go,
    input logic            busy,
    input logic            half_i,
    input logic            sample,
    input logic            irq,
    input logic            done,
    input logic [RES-1:0]  result,
    input logic [CH_W-1:0] mux_sel
);
    localparam int FC_W = $clog2(2 * FRAME + 2);

    logic            half_q;
    logic [FC_W-1:0] frame_cnt;
    logic [FC_W-1:0] samp_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q    <= 1'b0;
            frame_cnt <= '0;
            samp_cnt  <= '0;
        end else if (go) begin
            half_q    <= half_i;
            frame_cnt <= '0;
            samp_cnt  <= '0;
        end else begin
            if (busy)   frame_cnt <= frame_cnt + 1'b1;
            if (sample) samp_cnt  <= samp_cnt + 1'b1;
        end
    end

    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> $stable(result));

    p_done_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !done);

    p_mux_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mux_sel));

    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !go);

    p_sample_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample |-> busy);

    p_sample_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample) |-> (samp_cnt == FC_W'(half_q ? 2 * SAMPLE : SAMPLE)));

    p_frame_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (frame_cnt == FC_W'(half_q ? 2 * FRAME : FRAME)));
endmodule

bind sar_seq_top sar_seq_chk #(
    .RES    (RES),
    .FRAME  (FRAME),
    .SAMPLE (SAMPLE),
    .CH_W   (CH_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (go_w),
    .busy    (busy_w),
    .half_i  (half_clk_i),
    .sample  (sample_o),
    .irq     (irq_o),
    .done    (done_o),
    .result  (result_o),
    .mux_sel (mux_sel_o)
);

// File: tb/tb_sar_seq_top.sv
`timescale 1ns/1ps
module tb_sar_seq_top;
    localparam int FRAME   = 160;
    localparam int SAMPLE  = 12;
    localparam int PER_BIT = (FRAME - SAMPLE) / 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] ch_i = 3'd0;
    logic       half_clk_i = 1'b0;
    logic       cmp_i;
    logic [2:0] mux_sel_o;
    logic       sample_o;
    logic [7:0] dac_o;
    logic [7:0] result_o;
    logic       done_o;
    logic       irq_o;

    logic [7:0] vin [8];

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    // ideal comparator on the selected input
    assign cmp_i = (vin[mux_sel_o] >= dac_o);

    sar_seq_top dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .ch_i       (ch_i),
        .half_clk_i (half_clk_i),
        .cmp_i      (cmp_i),
        .mux_sel_o  (mux_sel_o),
        .sample_o   (sample_o),
        .dac_o      (dac_o),
        .result_o   (result_o),
        .done_o     (done_o),
        .irq_o      (irq_o)
    );

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            summary();
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] first_two_trial(input logic [7:0] v);
        return (v >= 8'h80 ? 8'h80 : 8'h00) | 8'h40;
    endfunction

    // One conversion; intr_at >= 0 injects a start while busy at that cycle.
    task automatic convert(input logic [2:0] ch, input logic half, input int intr_at);
        int m = half ? 2 : 1;
        int n_end = FRAME * m;
        int s_len = SAMPLE * m;
        int samp_hi = 0;
        int first_done = -1;
        int irq_hi = 0;
        logic mux_ok = 1'b1;
        logic res_hold = 1'b1;
        logic dac_ok0, dac_ok1;
        logic [7:0] prev = result_o;
        logic [7:0] exp_res = vin[ch];
        dac_ok0 = 1'b0;
        dac_ok1 = 1'b0;
        @(negedge clk);
        ch_i = ch;
        half_clk_i = half;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        ch_i = ~ch;
        for (int k = 0; k <= n_end; k++) begin
            if (mux_sel_o !== ch) mux_ok = 1'b0;
            if (sample_o) samp_hi++;
            if (irq_o) irq_hi++;
            if (done_o && first_done < 0) first_done = k;
            if (k < n_end && result_o !== prev) res_hold = 1'b0;
            if (k == 0) chk(done_o == 1'b0, "R8 done cleared by start", done_o, 0);
            if (k == s_len) dac_ok0 = (dac_o == 8'h80);
            if (k == s_len + PER_BIT * m) dac_ok1 = (dac_o == first_two_trial(exp_res));
            if (k == intr_at) begin
                start_i = 1'b1;
                ch_i = ch + 3'd3;
                half_clk_i = ~half;
            end else begin
                start_i = 1'b0;
            end
            if (k < n_end) @(negedge clk);
        end
        start_i = 1'b0;
        chk(mux_ok, "R2 mux holds latched channel", mux_sel_o, ch);
        chk(samp_hi == s_len, "R3 sample window length", samp_hi, s_len);
        chk(first_done == n_end, "R4 done at frame end", first_done, n_end);
        chk(irq_hi == 1 && irq_o, "R8 irq at completion", irq_hi, 1);
        chk(result_o == exp_res, "R5 result equals input", result_o, exp_res);
        chk(dac_ok0, "R6 first trial 0x80", dac_o, 8'h80);
        chk(dac_ok1, "R6 second trial code", 0, first_two_trial(exp_res));
        chk(res_hold, "R8 result held until completion", 0, 1);
        if (intr_at >= 0)
            chk(first_done == n_end && result_o == exp_res, "R7 busy start ignored", first_done, n_end);
        @(negedge clk);
        chk(!irq_o && done_o, "R8 irq one cycle, done sticky", {irq_o, done_o}, 1);
        repeat ($urandom_range(0, 5)) @(negedge clk);
        chk(done_o && result_o == exp_res, "R8 done and result sticky while idle", result_o, exp_res);
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 8; i++) vin[i] = 8'h00;
        repeat (3) @(negedge clk);
        chk(result_o == 0, "R1 reset result", result_o, 0);
        chk(!done_o && !irq_o && !sample_o, "R1 reset flags", {done_o, irq_o, sample_o}, 0);
        chk(mux_sel_o == 0, "R1 reset mux", mux_sel_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed search corners (R5), both rates (R4)
        vin[2] = 8'h00; convert(3'd2, 1'b0, -1);
        vin[5] = 8'hFF; convert(3'd5, 1'b1, -1);
        vin[0] = 8'h80; convert(3'd0, 1'b0, 5);
        vin[7] = 8'h7F; convert(3'd7, 1'b1, 300);

        // random conversions with busy starts (R7)
        for (int t = 0; t < 24; t++) begin
            logic h;
            int lim;
            for (int i = 0; i < 8; i++) vin[i] = 8'($urandom);
            h = 1'($urandom);
            lim = h ? 2 * FRAME - 1 : FRAME - 1;
            convert(3'($urandom), h, (t % 3 == 0) ? -1 : int'($urandom_range(0, lim)));
        end
        summary();
    end
endmodule